// File: doc/BRIEF.md
# CSMA/CD Collision Retry Controller

This block steers the transmit side of a half-duplex MAC through every attempt of one frame on a shared medium. A frame begins with `tx_start`. The block holds `tx_enable` high while the MAC sends and counts bit times on the `bit_tick` strobe. It watches `collision` and uses the bit count to split ordinary collisions from late ones. Each collision produces a jam burst. After an ordinary collision the block waits a truncated binary exponential backoff, counted in slot times, and then an inter-frame gap before it starts the next attempt.

When the frame ends, whether it was delivered or abandoned, `done` pulses and four status flags describe the outcome. These flags report one retry, several retries, too many collisions, or a late collision. An abandoned frame also raises `fifo_flush` so the transmit buffer discards it. Two mode inputs change the behaviour. One makes the first collision fatal. The other freezes the backoff and gap timers while receive carrier is present, which stretches the wait on a busy network. The random backoff draw comes from an internal LFSR whose seed is a parameter.

Top module: `csma_retry_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, `tx_enable`, `jam`, `done`, `fifo_flush` and all four status flags are 0.
- R2: In idle, `tx_start` raises `tx_enable` on the next clock. `tx_end` with no collision in the same cycle ends the frame: `done` goes high on the next clock, `fifo_flush` stays 0, and `tx_enable` drops.
- R3: A collision seen while transmitting enters the jam phase on the next clock. `jam` and `tx_enable` then both stay high for exactly JAM_BITS bit times.
- R4: After the jam that ends the nth attempt (n = 1 for the first collision), `tx_enable` stays low for r*SLOT_BITS + IPG_BITS bit times, where 0 <= r < 2^min(n, BK_LIMIT). The value r is the low min(n, BK_LIMIT) bits of the LFSR.
- R5: A frame that succeeds on its 2nd attempt sets `ok_one_retry`. A frame that succeeds on a later attempt sets `ok_multi_retry`. A frame that succeeds on its first attempt sets no flag. At most one flag is ever set.
- R6: When attempt MAX_ATTEMPTS (16 by default) collides, the jam is followed by `done`, `fifo_flush` and `fail_excess`, with `ok_one_retry` and `ok_multi_retry` at 0.
- R7: With `retry_disable` = 1, the first collision is followed by its jam and then `done`, `fifo_flush` and `fail_excess`, with no further attempt.
- R8: A collision that arrives when at least LATE_BITS bit times of the attempt have passed is late. After the jam, the block ends with `done`, `fifo_flush` and `fail_late`, and it does not retry. A collision after LATE_BITS-1 bit times is an ordinary collision and is retried.
- R9: With `alt_backoff` = 0, carrier present during the gap restarts the gap. The next attempt starts exactly IPG_BITS bit times after carrier drops.
- R10: With `alt_backoff` = 1, the slot and gap timers hold their value while carrier is present and resume when it drops. The remaining wait after carrier drops is r*SLOT_BITS + IPG_BITS.
- R11: `done` is a single-cycle pulse. The status flags keep their value until the next `tx_start`, which clears them.
- R12: All bit-time timers (frame length, jam, slot, gap) advance only in cycles where `bit_tick` = 1. With `bit_tick` held low, the jam phase does not end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_start | input | 1 | Begin a new frame (taken in idle only) |
| tx_end | input | 1 | MAC has sent the last bit of the current attempt |
| bit_tick | input | 1 | One-cycle strobe per bit time |
| collision | input | 1 | Collision detected on the medium |
| carrier_sense | input | 1 | Receive carrier present |
| retry_disable | input | 1 | Abandon the frame at the first collision |
| alt_backoff | input | 1 | Freeze slot and gap timing while carrier is present |
| tx_enable | output | 1 | MAC may drive the medium (data or jam) |
| jam | output | 1 | Jam pattern is being sent |
| fifo_flush | output | 1 | One-cycle request to discard the frame |
| done | output | 1 | One-cycle pulse at the end of the frame |
| ok_one_retry | output | 1 | Delivered after exactly one retry |
| ok_multi_retry | output | 1 | Delivered after more than one retry |
| fail_excess | output | 1 | Abandoned: attempts exhausted or retry disabled |
| fail_late | output | 1 | Abandoned: late collision |

## Verification
Every result comes from one register stage. `tx_enable` rises one clock after `tx_start`, or one clock after the last counted gap tick. `jam` rises one clock after the colliding cycle. `done`, `fifo_flush` and the flags appear one clock after `tx_end` or after the final jam tick. The bench drives and samples on the falling edge and counts falling edges between these events. It measures jam length and gap length as exact edge counts. The random backoff is checked arithmetically: the gap minus IPG_BITS must be a whole number of slots, below 2^min(n, BK_LIMIT). Carrier-hold scenarios count the edges after carrier drops.

// File: rtl/csma_retry_pkg.sv
package csma_retry_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_XMIT,
      ST_JAM,
      ST_BACKOFF,
      ST_GAP
   } txr_state_e;

   typedef struct packed {
      logic one_retry;
      logic multi_retry;
      logic excess;
      logic late;
   } txr_status_t;

   // Maximal-length feedback masks, bit i set for tap position i+1
   function automatic logic [31:0] lfsr_taps(input int w);
      case (w)
         4:       return 32'h0000_000C;
         5:       return 32'h0000_0014;
         6:       return 32'h0000_0030;
         7:       return 32'h0000_0060;
         8:       return 32'h0000_00B8;
         9:       return 32'h0000_0110;
         10:      return 32'h0000_0240;
         11:      return 32'h0000_0500;
         12:      return 32'h0000_0829;
         13:      return 32'h0000_100D;
         14:      return 32'h0000_2015;
         15:      return 32'h0000_6000;
         16:      return 32'h0000_D008;
         default: return 32'h0000_0000;
      endcase
   endfunction

endpackage

// File: rtl/csma_tick_counter.sv
module csma_tick_counter #(
   parameter int LIMIT    = 16,
   parameter bit SATURATE = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic adv,
   output logic hit
);

   localparam int CW = $clog2(LIMIT + 1);

   logic [CW-1:0] count;
   logic [CW-1:0] count_nx;

   generate
      if (LIMIT < 2) begin : g_bad_limit
         $error("csma_tick_counter: LIMIT must be at least 2");
      end

      if (SATURATE) begin : g_sat
         assign hit      = (count == CW'(LIMIT));
         assign count_nx = hit ? count : count + CW'(1);
      end else begin : g_wrap
         assign hit      = (count == CW'(LIMIT - 1));
         assign count_nx = hit ? '0 : count + CW'(1);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count <= '0;
      end else if (clr) begin
         count <= '0;
      end else if (adv) begin
         count <= count_nx;
      end
   end

   p_count_bound_r12: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CW'(LIMIT));

   p_hold_no_tick_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (!adv && !clr) |=> $stable(count));

endmodule

// File: rtl/csma_backoff_rng.sv
module csma_backoff_rng #(
   parameter int          W      = 10,
   parameter logic [31:0] SEED   = 32'h0000_01B3,
   parameter bit          GALOIS = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   output logic [W-1:0] value
);

   import csma_retry_pkg::*;

   localparam logic [31:0]  TAP_ALL = lfsr_taps(W);
   localparam logic [W-1:0] TAPS    = TAP_ALL[W-1:0];
   localparam logic [W-1:0] INIT    = SEED[W-1:0];

   logic [W-1:0] q;
   logic [W-1:0] q_nx;

   generate
      if (W < 4 || W > 16) begin : g_bad_width
         $error("csma_backoff_rng: W must be within 4..16");
      end
      if (INIT == '0) begin : g_bad_seed
         $error("csma_backoff_rng: SEED low bits must be nonzero");
      end

      if (GALOIS) begin : g_galois
         assign q_nx = q[0] ? ((q >> 1) ^ TAPS) : (q >> 1);
      end else begin : g_fibonacci
         assign q_nx = {q[W-2:0], ^(q & TAPS)};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= INIT;
      else        q <= q_nx;
   end

   assign value = q;

   p_rng_live_r4: assert property (@(posedge clk) disable iff (!rst_n)
      q != '0);

endmodule

// File: rtl/csma_retry_fsm.sv
module csma_retry_fsm #(
   parameter int MAX_ATTEMPTS = 16,
   parameter int SLOT_BITS    = 512,
   parameter int LATE_BITS    = 512,
   parameter int JAM_BITS     = 32,
   parameter int IPG_BITS     = 96,
   parameter int BK_LIMIT     = 10
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                tx_start,
   input  logic                tx_end,
   input  logic                bit_tick,
   input  logic                collision,
   input  logic                carrier_sense,
   input  logic                retry_disable,
   input  logic                alt_backoff,
   input  logic [BK_LIMIT-1:0] rnd,
   output logic                tx_enable,
   output logic                jam,
   output logic                fifo_flush,
   output logic                done,
   output csma_retry_pkg::txr_status_t status
);

   import csma_retry_pkg::*;

   localparam int AW = $clog2(MAX_ATTEMPTS + 1);
   localparam int RW = BK_LIMIT;

   txr_state_e    state;
   logic [AW-1:0] attempt;
   logic [RW-1:0] r_left;
   logic [RW-1:0] draw;
   logic          late_q;
   logic          done_q;
   logic          flush_q;
   txr_status_t   status_q;

   logic frame_late, jam_hit, slot_hit, gap_hit;
   logic freeze, slot_adv, gap_adv, gap_clr, jam_end;

   generate
      if (MAX_ATTEMPTS < 1) begin : g_bad_attempts
         $error("csma_retry_fsm: MAX_ATTEMPTS must be positive");
      end
      if (BK_LIMIT < 1) begin : g_bad_limit
         $error("csma_retry_fsm: BK_LIMIT must be positive");
      end
   endgenerate

   assign freeze   = alt_backoff & carrier_sense;
   assign slot_adv = bit_tick & (state == ST_BACKOFF) & ~freeze;
   assign gap_adv  = bit_tick & (state == ST_GAP) & ~carrier_sense;
   assign gap_clr  = (state != ST_GAP) | (carrier_sense & ~alt_backoff);
   assign jam_end  = bit_tick & jam_hit;

   csma_tick_counter #(.LIMIT(LATE_BITS), .SATURATE(1'b1)) u_frame_len (
      .clk(clk), .rst_n(rst_n),
      .clr(state != ST_XMIT),
      .adv(bit_tick & (state == ST_XMIT)),
      .hit(frame_late));

   csma_tick_counter #(.LIMIT(JAM_BITS), .SATURATE(1'b0)) u_jam_len (
      .clk(clk), .rst_n(rst_n),
      .clr(state != ST_JAM),
      .adv(bit_tick & (state == ST_JAM)),
      .hit(jam_hit));

   csma_tick_counter #(.LIMIT(SLOT_BITS), .SATURATE(1'b0)) u_slot_len (
      .clk(clk), .rst_n(rst_n),
      .clr(state != ST_BACKOFF),
      .adv(slot_adv),
      .hit(slot_hit));

   csma_tick_counter #(.LIMIT(IPG_BITS), .SATURATE(1'b0)) u_gap_len (
      .clk(clk), .rst_n(rst_n),
      .clr(gap_clr),
      .adv(gap_adv),
      .hit(gap_hit));

   // Truncated exponent: keep the low min(attempt, BK_LIMIT) random bits
   always_comb begin
      int k;
      k = (int'(attempt) < BK_LIMIT) ? int'(attempt) : BK_LIMIT;
      for (int i = 0; i < RW; i++) begin
         draw[i] = rnd[i] & (i < k);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         attempt  <= '0;
         r_left   <= '0;
         late_q   <= 1'b0;
         done_q   <= 1'b0;
         flush_q  <= 1'b0;
         status_q <= '0;
      end else begin
         done_q  <= 1'b0;
         flush_q <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (tx_start) begin
                  state    <= ST_XMIT;
                  attempt  <= AW'(1);
                  status_q <= '0;
               end
            end
            ST_XMIT: begin
               if (collision) begin
                  state  <= ST_JAM;
                  late_q <= frame_late;
               end else if (tx_end) begin
                  state                <= ST_IDLE;
                  done_q               <= 1'b1;
                  status_q.one_retry   <= (attempt == AW'(2));
                  status_q.multi_retry <= (attempt > AW'(2));
               end
            end
            ST_JAM: begin
               if (jam_end) begin
                  if (late_q) begin
                     state         <= ST_IDLE;
                     done_q        <= 1'b1;
                     flush_q       <= 1'b1;
                     status_q.late <= 1'b1;
                  end else if (retry_disable || attempt == AW'(MAX_ATTEMPTS)) begin
                     state           <= ST_IDLE;
                     done_q          <= 1'b1;
                     flush_q         <= 1'b1;
                     status_q.excess <= 1'b1;
                  end else begin
                     attempt <= attempt + AW'(1);
                     r_left  <= draw;
                     state   <= (draw == '0) ? ST_GAP : ST_BACKOFF;
                  end
               end
            end
            ST_BACKOFF: begin
               if (slot_adv && slot_hit) begin
                  if (r_left == RW'(1)) state <= ST_GAP;
                  else                  r_left <= r_left - RW'(1);
               end
            end
            ST_GAP: begin
               if (gap_adv && gap_hit) state <= ST_XMIT;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign tx_enable  = (state == ST_XMIT) || (state == ST_JAM);
   assign jam        = (state == ST_JAM);
   assign done       = done_q;
   assign fifo_flush = flush_q;
   assign status     = status_q;

   p_jam_tx_r3: assert property (@(posedge clk) disable iff (!rst_n)
      jam |-> tx_enable);

   p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q);

   p_flush_abort_r6: assert property (@(posedge clk) disable iff (!rst_n)
      flush_q |-> (done_q && !status_q.one_retry && !status_q.multi_retry));

   p_status_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(status_q));

   p_late_no_retry_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_JAM && late_q && jam_end) |=> (state == ST_IDLE && status_q.late));

   p_gap_wait_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_GAP && carrier_sense) |=> (state == ST_GAP));

   p_freeze_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_BACKOFF && freeze) |=> (state == ST_BACKOFF && $stable(r_left)));

endmodule

// File: rtl/csma_retry_ctrl.sv
module csma_retry_ctrl #(
   parameter int          MAX_ATTEMPTS = 16,
   parameter int          SLOT_BITS    = 512,
   parameter int          LATE_BITS    = 512,
   parameter int          JAM_BITS     = 32,
   parameter int          IPG_BITS     = 96,
   parameter int          BK_LIMIT     = 10,
   parameter int          RNG_W        = 10,
   parameter logic [31:0] RNG_SEED     = 32'h0000_01B3,
   parameter bit          RNG_GALOIS   = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tx_start,
   input  logic tx_end,
   input  logic bit_tick,
   input  logic collision,
   input  logic carrier_sense,
   input  logic retry_disable,
   input  logic alt_backoff,
   output logic tx_enable,
   output logic jam,
   output logic fifo_flush,
   output logic done,
   output logic ok_one_retry,
   output logic ok_multi_retry,
   output logic fail_excess,
   output logic fail_late
);

   import csma_retry_pkg::*;

   generate
      if (RNG_W < BK_LIMIT) begin : g_bad_rng
         $error("csma_retry_ctrl: RNG_W must cover BK_LIMIT bits");
      end
   endgenerate

   logic [RNG_W-1:0] rnd_full;
   txr_status_t      status;

   csma_backoff_rng #(.W(RNG_W), .SEED(RNG_SEED), .GALOIS(RNG_GALOIS)) u_rng (
      .clk(clk), .rst_n(rst_n), .value(rnd_full));

   csma_retry_fsm #(
      .MAX_ATTEMPTS(MAX_ATTEMPTS), .SLOT_BITS(SLOT_BITS), .LATE_BITS(LATE_BITS),
      .JAM_BITS(JAM_BITS), .IPG_BITS(IPG_BITS), .BK_LIMIT(BK_LIMIT)
   ) u_fsm (
      .clk(clk), .rst_n(rst_n),
      .tx_start(tx_start), .tx_end(tx_end), .bit_tick(bit_tick),
      .collision(collision), .carrier_sense(carrier_sense),
      .retry_disable(retry_disable), .alt_backoff(alt_backoff),
      .rnd(rnd_full[BK_LIMIT-1:0]),
      .tx_enable(tx_enable), .jam(jam), .fifo_flush(fifo_flush),
      .done(done), .status(status));

   assign ok_one_retry   = status.one_retry;
   assign ok_multi_retry = status.multi_retry;
   assign fail_excess    = status.excess;
   assign fail_late      = status.late;

endmodule

// File: tb/tb_csma_retry_ctrl.sv
`timescale 1ns/1ps
module tb_csma_retry_ctrl;

   localparam int MAXA = 16;
   localparam int SLOT = 4;
   localparam int LATE = 16;
   localparam int JAMB = 4;
   localparam int IPG  = 6;
   localparam int BKL  = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tx_start = 0, tx_end = 0, bit_tick = 1, collision = 0;
   logic carrier_sense = 0, retry_disable = 0, alt_backoff = 0;
   logic tx_enable, jam, fifo_flush, done;
   logic ok_one_retry, ok_multi_retry, fail_excess, fail_late;

   int total = 0;
   int bad = 0;

   always #2.5 clk = ~clk;

   csma_retry_ctrl #(.MAX_ATTEMPTS(MAXA), .SLOT_BITS(SLOT), .LATE_BITS(LATE),
      .JAM_BITS(JAMB), .IPG_BITS(IPG), .BK_LIMIT(BKL), .RNG_W(10),
      .RNG_SEED(32'h0000_02C7)) dut (
      .clk(clk), .rst_n(rst_n), .tx_start(tx_start), .tx_end(tx_end),
      .bit_tick(bit_tick), .collision(collision), .carrier_sense(carrier_sense),
      .retry_disable(retry_disable), .alt_backoff(alt_backoff),
      .tx_enable(tx_enable), .jam(jam), .fifo_flush(fifo_flush), .done(done),
      .ok_one_retry(ok_one_retry), .ok_multi_retry(ok_multi_retry),
      .fail_excess(fail_excess), .fail_late(fail_late));

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int flags();
      return {28'd0, ok_one_retry, ok_multi_retry, fail_excess, fail_late};
   endfunction

   task automatic start_frame();
      tx_start = 1;
      @(negedge clk);
      tx_start = 0;
      check(tx_enable == 1, "R2 tx_enable one clock after start", tx_enable, 1);
      check(flags() == 0, "R11 flags cleared by start", flags(), 0);
   endtask

   task automatic finish_ok(input int exp_flags, input string tag);
      tx_end = 1;
      @(negedge clk);
      tx_end = 0;
      check(done == 1 && fifo_flush == 0 && tx_enable == 0, "R2 success ends frame",
            {done, fifo_flush, tx_enable}, 3'b100);
      check(flags() == exp_flags, tag, flags(), exp_flags);
      @(negedge clk);
      check(done == 0, "R11 done lasts one cycle", done, 0);
      check(flags() == exp_flags, "R11 flags held after done", flags(), exp_flags);
   endtask

   // Collide now; returns at the first negedge after the jam
   task automatic collide();
      int  jl = 0;
      bit  tx_ok = 1;
      collision = 1;
      @(negedge clk);
      collision = 0;
      while (jam && jl < 1000) begin
         if (!tx_enable) tx_ok = 0;
         jl++;
         @(negedge clk);
      end
      check(jl == JAMB && tx_ok, "R3 jam length with tx_enable", jl, JAMB);
   endtask

   task automatic measure_gap(output int low);
      low = 0;
      while (!tx_enable && !done && low < 60000) begin
         low++;
         @(negedge clk);
      end
   endtask

   task automatic retry_once(input int n);
      int low;
      int k;
      int rem;
      collide();
      check(done == 0, "R4 no end after ordinary collision", done, 0);
      measure_gap(low);
      k   = (n < BKL) ? n : BKL;
      rem = low - IPG;
      check(rem >= 0 && rem % SLOT == 0 && rem / SLOT < (1 << k),
            "R4 backoff is r slots plus gap within range", low, IPG);
      check(tx_enable == 1, "R4 retry starts after backoff", tx_enable, 1);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int cnt;
      int errs;
      repeat (3) @(negedge clk);
      check(tx_enable == 0 && jam == 0 && done == 0 && fifo_flush == 0 && flags() == 0,
            "R1 outputs low in reset", {tx_enable, jam, done, fifo_flush}, 0);
      rst_n = 1;
      @(negedge clk);
      check(tx_enable == 0 && jam == 0 && done == 0 && flags() == 0,
            "R1 outputs low after reset", {tx_enable, jam, done}, 0);

      // R2: clean frame
      start_frame();
      repeat (10) @(negedge clk);
      check(tx_enable == 1, "R2 tx_enable held during frame", tx_enable, 1);
      finish_ok(0, "R5 first-try success sets no flag");

      // R5: one retry
      start_frame();
      retry_once(1);
      finish_ok(4'b1000, "R5 one retry flag");

      // R5: three retries
      start_frame();
      for (int n = 1; n <= 3; n++) retry_once(n);
      finish_ok(4'b0100, "R5 multi retry flag");

      // R12: jam frozen without bit_tick
      start_frame();
      collision = 1;
      bit_tick  = 0;
      @(negedge clk);
      collision = 0;
      errs = 0;
      for (int i = 0; i < 20; i++) begin
         if (!jam) errs++;
         @(negedge clk);
      end
      check(errs == 0, "R12 jam holds with no tick", errs, 0);
      bit_tick = 1;
      cnt = 0;
      while (jam && cnt < 100) begin
         cnt++;
         @(negedge clk);
      end
      check(cnt == JAMB, "R12 jam resumes for full length", cnt, JAMB);
      measure_gap(cnt);
      finish_ok(4'b1000, "R12 frame completes after gated jam");

      // R8: late collision at the cutoff
      start_frame();
      repeat (LATE) @(negedge clk);
      collide();
      check(done == 1 && fifo_flush == 1 && flags() == 4'b0001,
            "R8 late collision aborts", flags(), 1);
      errs = 0;
      for (int i = 0; i < 30; i++) begin
         @(negedge clk);
         if (tx_enable) errs++;
      end
      check(errs == 0, "R8 no retry after late collision", errs, 0);

      // R8: one bit before the cutoff is ordinary
      start_frame();
      repeat (LATE - 1) @(negedge clk);
      collide();
      check(done == 0 && fifo_flush == 0, "R8 collision before cutoff retried", done, 0);
      measure_gap(cnt);
      check(tx_enable == 1, "R8 retry after early collision", tx_enable, 1);
      finish_ok(4'b1000, "R8 early collision then one-retry success");

      // R7: retries disabled
      retry_disable = 1;
      start_frame();
      collide();
      check(done == 1 && fifo_flush == 1 && flags() == 4'b0010,
            "R7 first collision abandons", flags(), 2);
      errs = 0;
      for (int i = 0; i < 30; i++) begin
         @(negedge clk);
         if (tx_enable) errs++;
      end
      check(errs == 0, "R7 no retry when disabled", errs, 0);
      retry_disable = 0;

      // R6: attempts exhausted
      start_frame();
      for (int n = 1; n < MAXA; n++) retry_once(n);
      collide();
      check(done == 1 && fifo_flush == 1 && flags() == 4'b0010,
            "R6 sixteenth collision abandons", flags(), 2);
      @(negedge clk);
      check(fifo_flush == 0 && flags() == 4'b0010, "R11 flags held, flush pulse", flags(), 2);
      start_frame();
      finish_ok(0, "R11 new frame reports no stale flag");

      // R9: carrier restarts the gap in normal mode
      start_frame();
      collide();
      carrier_sense = 1;
      errs = 0;
      for (int i = 0; i < 50; i++) begin
         @(negedge clk);
         if (tx_enable) errs++;
      end
      check(errs == 0, "R9 no attempt while carrier present", errs, 0);
      carrier_sense = 0;
      repeat (IPG - 1) @(negedge clk);
      check(tx_enable == 0, "R9 gap not yet complete", tx_enable, 0);
      @(negedge clk);
      check(tx_enable == 1, "R9 attempt exactly one gap after carrier", tx_enable, 1);
      finish_ok(4'b1000, "R9 frame completes");

      // R10: alternative mode freezes backoff and gap
      alt_backoff = 1;
      start_frame();
      collide();
      carrier_sense = 1;
      errs = 0;
      for (int i = 0; i < 300; i++) begin
         @(negedge clk);
         if (tx_enable) errs++;
      end
      check(errs == 0, "R10 timers frozen under carrier", errs, 0);
      carrier_sense = 0;
      cnt = 0;
      while (!tx_enable && cnt < 1000) begin
         @(negedge clk);
         cnt++;
      end
      check(cnt == IPG || cnt == IPG + SLOT, "R10 remaining wait after carrier drop",
            cnt, IPG);
      finish_ok(4'b1000, "R10 frame completes");
      alt_backoff = 0;

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule